// File: doc/BRIEF.md
# Multiplicative Frequency Boost Controller

This block turns threshold-crossing events from a memory activity monitor into a frequency recommendation. It keeps a boost value in kHz. A "sustained high" event multiplies the boost by a growth percentage and then adds a fixed step. A "sustained low" event multiplies it by a decay percentage. The boost is clamped at the highest clock frequency the memory can run at. It snaps to zero once it falls below half the step.

The block drives two enable flags that the activity monitor uses to arm its own high and low event generators. When the boost reaches its ceiling, the high generator is disarmed. When the boost reaches zero, the low generator is disarmed. Every event re-arms the generator that its own limit check does not disarm.

On request, the block computes a target frequency. It divides the smoothed activity average by the sampling period, scales the result by the inverse of the high threshold, and adds the current boost. All multiplications and divisions run one at a time on a shared shift-and-add multiplier and a shared restoring divider. A one-cycle done strobe marks each result.

Top module: `freq_boost_ctrl`

## Requirements
- R1: After reset, the boost is 0, the target is 0, both enable flags are 1 and the done strobe is 0.
- R2: A high event sets the boost to floor(boost × up_coef / 100) + 16000 and sets both enable flags. If that value is at or above `fmax_i`, the boost becomes `fmax_i` instead, the high-arm flag is cleared and the low-arm flag is set.
- R3: A low event sets the boost to floor(boost × dn_coef / 100), with `dn_coef_i` at most 100, and sets both enable flags. If that value is below 8000, the boost becomes 0 instead, the low-arm flag is cleared and the high-arm flag is set.
- R4: Every completed event leaves at least one enable flag set. An event of either kind restores a flag that an earlier limit had cleared, unless its own limit check clears that flag again.
- R5: Pending work is served in a fixed priority order: high event first, then low event, then target request. When a high event and a low event arrive in the same cycle, both are applied, the high one first.
- R6: A target request sets the target to floor(floor(floor(avg / 12) × floor(10000 / up_thr)) / 100) + boost, with `up_thr_i` in the range 1..100. The result saturates at all ones of the frequency width. Event completions leave the target unchanged.
- R7: `done_o` is high for exactly one cycle per completed operation, in the same cycle the result appears on the outputs. The boost, the enable flags and the target change only in that cycle.
- R8: Each kind of request holds at most one pending entry. Strobes that arrive while an operation runs are kept. Repeated strobes of one kind before it is served merge into a single operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_evt_i | input | 1 | Sustained-high event strobe |
| dn_evt_i | input | 1 | Sustained-low event strobe |
| tgt_req_i | input | 1 | Target computation request strobe |
| avg_cnt_i | input | AVG_W | Smoothed activity average count |
| fmax_i | input | FREQ_W | Highest allowed frequency, kHz |
| up_coef_i | input | PCT_W | Growth percentage |
| dn_coef_i | input | PCT_W | Decay percentage |
| up_thr_i | input | PCT_W | High-threshold percentage used for target scaling |
| target_o | output | FREQ_W | Recommended frequency, kHz |
| boost_o | output | FREQ_W | Current boost, kHz |
| above_en_o | output | 1 | Arm flag for the high event generator |
| below_en_o | output | 1 | Arm flag for the low event generator |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default widths: 32-bit frequency and average, 10-bit percentages and a 12 ms period. It drives a small ceiling of 924000 kHz, so a short run of high events from zero reaches the clamp, and a short run of low events from the ceiling reaches the snap to zero. It covers both coefficient sets (200/50 with a threshold of 60, and 800/90 with a threshold of 27). It also drives a full-scale average with a threshold of 1, which makes the target sum exceed 32 bits and exercises saturation. Simultaneous strobes, and strobes issued while the datapath is busy, exercise the priority order and the merging of repeated strobes.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

   // request sources; index order is the service priority (lowest index first)
   localparam int unsigned IDX_UP  = 0;
   localparam int unsigned IDX_DN  = 1;
   localparam int unsigned IDX_TGT = 2;
   localparam int unsigned N_SRC   = 3;

   typedef enum logic [1:0] {
      OP_UP  = 2'd0,
      OP_DN  = 2'd1,
      OP_TGT = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_EMUL = 3'd1,   // boost x coefficient
      ST_EDIV = 3'd2,   // / 100, then apply limits
      ST_TDA  = 3'd3,   // average / period
      ST_TDS  = 3'd4,   // 10000 / threshold
      ST_TMUL = 3'd5,   // product of both quotients
      ST_TDP  = 3'd6    // / 100, then add boost
   } st_e;

endpackage

// File: rtl/fbc_seq_mul.sv
module fbc_seq_mul #(
   parameter int unsigned W = 32
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           go_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic           done_o,
   output logic [2*W-1:0] prod_o
);
   localparam int unsigned PW = 2 * W;
   localparam int unsigned CW = $clog2(W + 1);

   logic [PW-1:0] acc_q, mcd_q;
   logic [W-1:0]  mpl_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;

   initial begin
      mul_width_chk: assert (W >= 2) else $error("multiplier width too small");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         mcd_q  <= '0;
         mpl_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i) begin
            acc_q <= '0;
            mcd_q <= PW'(a_i);
            mpl_q <= b_i;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (mpl_q[0]) acc_q <= acc_q + mcd_q;
            mcd_q <= mcd_q << 1;
            mpl_q <= mpl_q >> 1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign prod_o = acc_q;

   // R7
   mul_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

endmodule

// File: rtl/fbc_seq_div.sv
module fbc_seq_div #(
   parameter int unsigned NW = 64,
   parameter int unsigned DW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          go_i,
   input  logic [NW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic          done_o,
   output logic [NW-1:0] quo_o
);
   localparam int unsigned CW = $clog2(NW + 1);

   logic [DW-1:0] rem_q, den_q;
   logic [NW-1:0] quo_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;
   logic [DW:0]   trial;

   initial begin
      div_width_chk: assert (NW >= DW && DW >= 2) else $error("divider widths inconsistent");
   end

   assign trial = {rem_q, quo_q[NW-1]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         den_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i) begin
            rem_q <= '0;
            den_q <= den_i;
            quo_q <= num_i;
            cnt_q <= CW'(NW);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (trial >= {1'b0, den_q}) begin
               rem_q <= DW'(trial - {1'b0, den_q});
               quo_q <= {quo_q[NW-2:0], 1'b1};
            end else begin
               rem_q <= trial[DW-1:0];
               quo_q <= {quo_q[NW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quo_o  = quo_q;

   // R7
   div_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

endmodule

// File: rtl/fbc_evt_arb.sv
module fbc_evt_arb #(
   parameter int unsigned N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic         take_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] gnt_o
);
   initial begin
      arb_n_chk: assert (N >= 1) else $error("arbiter needs a source");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic p_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) p_q <= 1'b0;
         else         p_q <= (p_q & ~(take_i & gnt_o[i])) | req_i[i];
      end
      assign pend_o[i] = p_q;

      // R8
      pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (p_q && !(take_i && gnt_o[i])) |=> p_q);
   end

   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < N; i++) begin
         gnt_o[i] = pend_o[i] & ~seen;
         seen     = seen | pend_o[i];
      end
   end

endmodule

// File: rtl/freq_boost_ctrl.sv
module freq_boost_ctrl
   import fbc_pkg::*;
#(
   parameter int unsigned FREQ_W    = 32,
   parameter int unsigned AVG_W     = 32,
   parameter int unsigned PCT_W     = 10,
   parameter int unsigned PERIOD_MS = 12,
   parameter int unsigned STEP_KHZ  = 16000,
   parameter int unsigned PCT_SCALE = 100
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              up_evt_i,
   input  logic              dn_evt_i,
   input  logic              tgt_req_i,
   input  logic [AVG_W-1:0]  avg_cnt_i,
   input  logic [FREQ_W-1:0] fmax_i,
   input  logic [PCT_W-1:0]  up_coef_i,
   input  logic [PCT_W-1:0]  dn_coef_i,
   input  logic [PCT_W-1:0]  up_thr_i,
   output logic [FREQ_W-1:0] target_o,
   output logic [FREQ_W-1:0] boost_o,
   output logic              above_en_o,
   output logic              below_en_o,
   output logic              done_o
);
   localparam int unsigned PROD_W      = 2 * FREQ_W;
   localparam int unsigned SNAP_KHZ    = STEP_KHZ / 2;
   localparam int unsigned SUSTAIN_NUM = PCT_SCALE * PCT_SCALE;

   initial begin
      cfg_width_chk: assert (AVG_W <= FREQ_W && PCT_W < FREQ_W)
         else $error("average or percentage width exceeds frequency width");
      cfg_const_chk: assert (PERIOD_MS >= 1 && PCT_SCALE >= 1 && STEP_KHZ >= 2)
         else $error("period, scale and step must be nonzero");
   end

   // ---------------- request capture ----------------
   logic [N_SRC-1:0] req, pend, gnt;
   logic             take;
   st_e              st_q;

   assign req[IDX_UP]  = up_evt_i;
   assign req[IDX_DN]  = dn_evt_i;
   assign req[IDX_TGT] = tgt_req_i;
   assign take         = (st_q == ST_IDLE) && (|pend);

   fbc_evt_arb #(.N(N_SRC)) arb_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .take_i (take),
      .pend_o (pend),
      .gnt_o  (gnt)
   );

   // ---------------- shared arithmetic ----------------
   logic                mul_go_q, mul_done;
   logic [FREQ_W-1:0]   mul_a_q, mul_b_q;
   logic [PROD_W-1:0]   mul_p;
   logic                div_go_q, div_done;
   logic [PROD_W-1:0]   div_n_q, div_q;
   logic [FREQ_W-1:0]   div_d_q;

   fbc_seq_mul #(.W(FREQ_W)) mul_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (mul_go_q),
      .a_i    (mul_a_q),
      .b_i    (mul_b_q),
      .done_o (mul_done),
      .prod_o (mul_p)
   );

   fbc_seq_div #(.NW(PROD_W), .DW(FREQ_W)) div_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (div_go_q),
      .num_i  (div_n_q),
      .den_i  (div_d_q),
      .done_o (div_done),
      .quo_o  (div_q)
   );

   // ---------------- result shaping ----------------
   op_e               op_q;
   logic [FREQ_W-1:0] boost_q, tgt_q, hold_q;
   logic              abv_q, blw_q, done_q;
   logic [PROD_W:0]   up_sum, tgt_sum;
   logic              up_sat, dn_snap, tgt_sat;

   assign up_sum  = {1'b0, div_q} + (PROD_W+1)'(STEP_KHZ);
   assign up_sat  = up_sum >= (PROD_W+1)'(fmax_i);
   assign dn_snap = div_q < PROD_W'(SNAP_KHZ);
   assign tgt_sum = {1'b0, div_q} + (PROD_W+1)'(boost_q);
   assign tgt_sat = |tgt_sum[PROD_W:FREQ_W];

   // ---------------- sequencer ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         op_q     <= OP_UP;
         boost_q  <= '0;
         tgt_q    <= '0;
         hold_q   <= '0;
         abv_q    <= 1'b1;
         blw_q    <= 1'b1;
         done_q   <= 1'b0;
         mul_go_q <= 1'b0;
         mul_a_q  <= '0;
         mul_b_q  <= '0;
         div_go_q <= 1'b0;
         div_n_q  <= '0;
         div_d_q  <= '0;
      end else begin
         mul_go_q <= 1'b0;
         div_go_q <= 1'b0;
         done_q   <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (take) begin
                  if (gnt[IDX_TGT]) begin
                     op_q     <= OP_TGT;
                     div_n_q  <= PROD_W'(avg_cnt_i);
                     div_d_q  <= FREQ_W'(PERIOD_MS);
                     div_go_q <= 1'b1;
                     st_q     <= ST_TDA;
                  end else begin
                     op_q     <= gnt[IDX_UP] ? OP_UP : OP_DN;
                     mul_a_q  <= boost_q;
                     mul_b_q  <= FREQ_W'(gnt[IDX_UP] ? up_coef_i : dn_coef_i);
                     mul_go_q <= 1'b1;
                     st_q     <= ST_EMUL;
                  end
               end
            end
            ST_EMUL: begin
               if (mul_done) begin
                  div_n_q  <= mul_p;
                  div_d_q  <= FREQ_W'(PCT_SCALE);
                  div_go_q <= 1'b1;
                  st_q     <= ST_EDIV;
               end
            end
            ST_EDIV: begin
               if (div_done) begin
                  abv_q <= 1'b1;
                  blw_q <= 1'b1;
                  if (op_q == OP_UP) begin
                     if (up_sat) begin
                        boost_q <= fmax_i;
                        abv_q   <= 1'b0;
                     end else begin
                        boost_q <= up_sum[FREQ_W-1:0];
                     end
                  end else begin
                     if (dn_snap) begin
                        boost_q <= '0;
                        blw_q   <= 1'b0;
                     end else begin
                        boost_q <= div_q[FREQ_W-1:0];
                     end
                  end
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            ST_TDA: begin
               if (div_done) begin
                  hold_q   <= div_q[FREQ_W-1:0];
                  div_n_q  <= PROD_W'(SUSTAIN_NUM);
                  div_d_q  <= FREQ_W'(up_thr_i);
                  div_go_q <= 1'b1;
                  st_q     <= ST_TDS;
               end
            end
            ST_TDS: begin
               if (div_done) begin
                  mul_a_q  <= hold_q;
                  mul_b_q  <= div_q[FREQ_W-1:0];
                  mul_go_q <= 1'b1;
                  st_q     <= ST_TMUL;
               end
            end
            ST_TMUL: begin
               if (mul_done) begin
                  div_n_q  <= mul_p;
                  div_d_q  <= FREQ_W'(PCT_SCALE);
                  div_go_q <= 1'b1;
                  st_q     <= ST_TDP;
               end
            end
            ST_TDP: begin
               if (div_done) begin
                  tgt_q  <= tgt_sat ? '1 : tgt_sum[FREQ_W-1:0];
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign target_o   = tgt_q;
   assign boost_o    = boost_q;
   assign above_en_o = abv_q;
   assign below_en_o = blw_q;
   assign done_o     = done_q;

   // ---------------- checks ----------------
   // R7
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   // R7
   quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_q |-> ($stable(boost_q) && $stable(abv_q) && $stable(blw_q) && $stable(tgt_q)));

   // R2
   up_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_EDIV && div_done && op_q == OP_UP) |=> (boost_q <= $past(fmax_i)) && blw_q);

   // R3
   dn_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_EDIV && div_done && op_q == OP_DN) |=> abv_q && (blw_q == (boost_q != '0)));

   // R4
   en_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abv_q || blw_q);

   // R5
   up_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take && pend[IDX_UP]) |=> (op_q == OP_UP));

   // R6
   tgt_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && op_q != OP_TGT) |-> $stable(tgt_q));

endmodule

// File: tb/freq_boost_ctrl_tb_top.sv
`timescale 1ns/1ps
module freq_boost_ctrl_tb_top;
   localparam int FW = 32, AW = 32, PW = 10, PER = 12, STEP = 16000;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          up_e = 1'b0, dn_e = 1'b0, tg_r = 1'b0;
   logic [AW-1:0] avg = '0;
   logic [FW-1:0] fmax = 32'd924000;
   logic [PW-1:0] upc = 10'd200, dnc = 10'd50, thr = 10'd60;
   logic [FW-1:0] target, boost;
   logic          abv, blw, done;

   int n_tests = 0, n_fail = 0, n_done = 0, cyc = 0;

   // reference model state
   longint m_boost, m_tgt, v;
   bit     m_abv, m_blw, m_busy;
   bit     m_pend [3];
   int     m_op;
   bit     su, sd, stg;
   string  tg;

   always #2.5 clk = ~clk;

   freq_boost_ctrl dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .up_evt_i   (up_e),
      .dn_evt_i   (dn_e),
      .tgt_req_i  (tg_r),
      .avg_cnt_i  (avg),
      .fmax_i     (fmax),
      .up_coef_i  (upc),
      .dn_coef_i  (dnc),
      .up_thr_i   (thr),
      .target_o   (target),
      .boost_o    (boost),
      .above_en_o (abv),
      .below_en_o (blw),
      .done_o     (done)
   );

   task automatic chk(string tag, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // cycle-by-cycle reference model, evaluated after each rising edge settles
   always begin
      @(posedge clk);
      su = up_e; sd = dn_e; stg = tg_r;
      #2;
      cyc++;
      if (!rst_n) begin
         m_boost = 0; m_tgt = 0; m_abv = 1; m_blw = 1; m_busy = 0; m_op = 0;
         for (int i = 0; i < 3; i++) m_pend[i] = 0;
      end else begin
         tg = "R7";
         if (!m_busy) begin
            for (int i = 0; i < 3; i++)
               if (m_op == 0 && m_pend[i]) begin m_op = i + 1; m_pend[i] = 0; end
            if (m_op != 0) m_busy = 1;
         end
         if (done) begin
            n_done++;
            if (!m_busy) begin
               n_tests++; n_fail++;
               $display("FAIL R7: actual done=1 expected done=0 (no operation running)");
            end else begin
               case (m_op)
                  1: begin
                     v = m_boost * upc / 100 + STEP;
                     if (v >= fmax) begin m_boost = fmax; m_abv = 0; m_blw = 1; end
                     else begin m_boost = v; m_abv = 1; m_blw = 1; end
                     tg = "R2";
                  end
                  2: begin
                     v = m_boost * dnc / 100;
                     if (v < STEP / 2) begin m_boost = 0; m_blw = 0; m_abv = 1; end
                     else begin m_boost = v; m_abv = 1; m_blw = 1; end
                     tg = "R3";
                  end
                  default: begin
                     v = ((longint'(avg) / PER) * (10000 / longint'(thr))) / 100 + m_boost;
                     if (v > 64'h0000_0000_FFFF_FFFF) v = 64'h0000_0000_FFFF_FFFF;
                     m_tgt = v;
                     tg = "R6";
                  end
               endcase
               m_busy = 0; m_op = 0;
            end
         end
         if (su) m_pend[0] = 1;
         if (sd) m_pend[1] = 1;
         if (stg) m_pend[2] = 1;
         chk({tg, " boost"}, longint'(boost), m_boost);
         chk({tg, " above_en"}, longint'(abv), longint'(m_abv));
         chk({tg, " below_en"}, longint'(blw), longint'(m_blw));
         chk({tg, " target"}, longint'(target), m_tgt);
      end
   end

   // watchdog
   always begin
      @(posedge clk);
      if (cyc >= 200000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic pulse(bit u, bit d, bit t);
      @(posedge clk); #1;
      up_e = u; dn_e = d; tg_r = t;
      @(posedge clk); #1;
      up_e = 0; dn_e = 0; tg_r = 0;
   endtask

   task automatic wait_idle();
      do begin
         @(posedge clk); #3;
      end while (m_busy || m_pend[0] || m_pend[1] || m_pend[2]);
   endtask

   task automatic run(bit u, bit d, bit t);
      pulse(u, d, t);
      wait_idle();
   endtask

   initial begin
      int base;
      repeat (4) @(posedge clk);
      #3;
      // R1 reset state
      chk("R1 boost", longint'(boost), 0);
      chk("R1 target", longint'(target), 0);
      chk("R1 above_en", longint'(abv), 1);
      chk("R1 below_en", longint'(blw), 1);
      chk("R1 done", longint'(done), 0);
      @(posedge clk); #1; rst_n = 1;

      // R2 growth from zero up to the ceiling
      run(1, 0, 0);
      chk("R2 first step", longint'(boost), 16000);
      for (int k = 0; k < 5; k++) run(1, 0, 0);
      chk("R2 clamp", longint'(boost), 924000);
      chk("R2 above cleared", longint'(abv), 0);
      run(1, 0, 0);
      chk("R2 clamp held", longint'(boost), 924000);

      // R3 decay to the snap point
      run(0, 1, 0);
      chk("R3 decay", longint'(boost), 462000);
      chk("R4 above restored", longint'(abv), 1);
      for (int k = 0; k < 6; k++) run(0, 1, 0);
      chk("R3 snap", longint'(boost), 0);
      chk("R3 below cleared", longint'(blw), 0);
      run(0, 1, 0);
      chk("R3 stays zero", longint'(boost), 0);

      // R4 high event re-arms the low generator
      run(1, 0, 0);
      chk("R4 below restored", longint'(blw), 1);

      // R6 target
      avg = 32'd1200000;
      run(0, 0, 1);
      chk("R6 target", longint'(target), 182000);

      // R5 simultaneous high and low
      base = n_done;
      pulse(1, 1, 0);
      while (n_done == base) begin @(posedge clk); #3; end
      chk("R5 high served first", longint'(boost), 48000);
      wait_idle();
      chk("R5 low served next", longint'(boost), 24000);

      // R8 strobes during a busy target merge per kind
      base = n_done;
      pulse(0, 0, 1);
      pulse(1, 0, 0);
      pulse(1, 1, 0);
      wait_idle();
      chk("R8 operation count", longint'(n_done - base), 3);
      chk("R8 final boost", longint'(boost), 32000);

      // second coefficient set
      upc = 10'd800; dnc = 10'd90; thr = 10'd27;
      run(1, 0, 0);
      chk("R2 steep growth", longint'(boost), 272000);
      run(1, 0, 0);
      chk("R2 steep clamp", longint'(boost), 924000);
      run(0, 1, 0);
      chk("R3 gentle decay", longint'(boost), 831600);
      avg = 32'd50000;
      run(0, 0, 1);
      chk("R6 target set two", longint'(target), 847014);
      avg = 32'd0;
      run(0, 0, 1);
      chk("R6 zero average", longint'(target), 831600);

      // R6 saturation
      avg = 32'hFFFF_FFFF; thr = 10'd1;
      run(0, 0, 1);
      chk("R6 saturation", longint'(target), 64'h0000_0000_FFFF_FFFF);

      repeat (3) @(posedge clk);
      summary();
   end
endmodule